// File: doc/BRIEF.md
# Programmable Toggle Square-Wave Generator

This block is a register-controlled timer clocked by the bus clock. It drives a square wave onto an interrupt-output pin. Software programs a control word that holds a tick count, a three-bit mode and a diagnostic bit. While the mode selects toggling, the output level inverts once every COUNT+1 bus-clock ticks, so one full period is 2*(COUNT+1) ticks. Reading the control word returns the programmed fields together with the live output level. Software can therefore sample the waveform it has set up and time it against a reference clock of its own, for example to work out the bus clock frequency.

A second register, the general-purpose control word, holds an output-enable bit and a direction field. The pin driver is active only when both of them permit it. A write to the control word restarts the tick counter and forces the output low, so the first half-period after the write is exact. Writing an all-zero control word returns the generator to its power-on state.

Register access uses a simple port. A write strobe carries an address bit and a data word, and the read data follows a read address combinationally.

Top module: `sqwave_gen`

## Requirements
- R1: After reset the control word and the general-purpose word both read as zero, the output level is low, and pin_oe_o and pin_o are 0.
- R2: A write to address 0 stores the count in bits [15:0], the mode in bits [18:16] and the diagnostic bit in bit 19. A read of address 0 returns these same values in the same positions.
- R3: With mode 3'b111 (toggle), the output level inverts on the (COUNT+1)-th clock edge after the write edge, and on every COUNT+1 edges after that. Between those edges it holds steady.
- R4: In toggle mode the full output period is 2*(COUNT+1) clock edges. A count of 63 gives a period of 128.
- R5: Every write to address 0 clears the tick counter and drives the output low on that edge. This also holds when the write edge coincides with a scheduled inversion.
- R6: Any mode value other than 3'b111 holds the output level low.
- R7: Writing zero to address 0 returns the control word and the output to their power-on values and leaves the general-purpose word unchanged.
- R8: A write to address 1 stores the output-enable bit in bit 0 and the direction field in bits [2:1]. pin_oe_o is 1 only when the enable bit is 1 and the direction field is 2'b00. pin_o equals the output level while pin_oe_o is 1 and is 0 otherwise.
- R9: Bit 20 of a read of address 0 always shows the present output level.
- R10: A count of 0 in toggle mode inverts the output on every clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 1 | Write address: 0 selects the control word, 1 the general-purpose word |
| wr_data_i | input | 32 | Write data |
| rd_addr_i | input | 1 | Read address |
| rd_data_o | output | 32 | Read data, combinational from rd_addr_i |
| pin_o | output | 1 | Gated square-wave output |
| pin_oe_o | output | 1 | Pin driver enable |

## Verification
Two functions can fall in the same cycle: a control-word write and the terminal tick that would invert the output. The bench provokes this by waiting exactly COUNT edges after a toggle-mode write and then issuing a second write whose edge is the one scheduled for the inversion. It judges the result by reading the level bit low after that edge and by checking that the new phase starts from zero. A gating change while the level is high is also checked, so that the enable logic and the toggle path are seen acting together.

// File: rtl/sqw_pkg.sv
package sqw_pkg;
  localparam int unsigned MODE_W = 3;
  localparam logic [MODE_W-1:0] MODE_TOGGLE = 3'b111;
  localparam logic [1:0] DIR_OUT = 2'b00;

  typedef enum logic {
    ADDR_CTRL = 1'b0,
    ADDR_GPC  = 1'b1
  } reg_addr_e;
endpackage

// File: rtl/sqw_regs.sv
module sqw_regs
  import sqw_pkg::*;
#(
  parameter int unsigned CNT_W  = 16,
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic              wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              rd_addr_i,
  input  logic              level_i,
  output logic [CNT_W-1:0]  count_o,
  output logic [MODE_W-1:0] mode_o,
  output logic              diag_o,
  output logic              oe_o,
  output logic [1:0]        dir_o,
  output logic              ctrl_load_o,
  output logic [DATA_W-1:0] rd_data_o
);
  localparam int unsigned MODE_LSB  = CNT_W;
  localparam int unsigned DIAG_BIT  = CNT_W + MODE_W;
  localparam int unsigned LEVEL_BIT = DIAG_BIT + 1;

  logic gpc_load;

  assign ctrl_load_o = wr_en_i && (reg_addr_e'(wr_addr_i) == ADDR_CTRL);
  assign gpc_load    = wr_en_i && (reg_addr_e'(wr_addr_i) == ADDR_GPC);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      count_o <= '0;
      mode_o  <= '0;
      diag_o  <= 1'b0;
    end else if (ctrl_load_o) begin
      count_o <= wr_data_i[CNT_W-1:0];
      mode_o  <= wr_data_i[MODE_LSB +: MODE_W];
      diag_o  <= wr_data_i[DIAG_BIT];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      oe_o  <= 1'b0;
      dir_o <= '0;
    end else if (gpc_load) begin
      oe_o  <= wr_data_i[0];
      dir_o <= wr_data_i[2:1];
    end
  end

  always_comb begin
    rd_data_o = '0;
    if (reg_addr_e'(rd_addr_i) == ADDR_CTRL) begin
      rd_data_o[CNT_W-1:0]           = count_o;
      rd_data_o[MODE_LSB +: MODE_W]  = mode_o;
      rd_data_o[DIAG_BIT]            = diag_o;
      rd_data_o[LEVEL_BIT]           = level_i;
    end else begin
      rd_data_o[0]   = oe_o;
      rd_data_o[2:1] = dir_o;
    end
  end

  // R2: a control write lands in the fields one edge later
  assert_ctrl_store_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctrl_load_o |=> (count_o == $past(wr_data_i[CNT_W-1:0]))
                 && (mode_o == $past(wr_data_i[MODE_LSB +: MODE_W])));

  // R7: a general-purpose word is untouched by control writes
  assert_gpc_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !gpc_load |=> $stable(oe_o) && $stable(dir_o));
endmodule

// File: rtl/sqw_tick.sv
module sqw_tick
  import sqw_pkg::*;
#(
  parameter int unsigned CNT_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [CNT_W-1:0]  count_i,
  input  logic [MODE_W-1:0] mode_i,
  output logic              level_o
);
  logic [CNT_W-1:0] tick_q;
  logic             toggle_en;
  logic             terminal;

  assign toggle_en = (mode_i == MODE_TOGGLE);
  assign terminal  = (tick_q == count_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tick_q  <= '0;
      level_o <= 1'b0;
    end else if (load_i || !toggle_en) begin
      // write restarts the phase; non-toggle modes park low
      tick_q  <= '0;
      level_o <= 1'b0;
    end else if (terminal) begin
      tick_q  <= '0;
      level_o <= ~level_o;
    end else begin
      tick_q  <= tick_q + 1'b1;
    end
  end

  assert_reload_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> (tick_q == '0) && !level_o);

  assert_hold_low_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !toggle_en |-> !level_o);

  assert_tick_bound_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    toggle_en |-> tick_q <= count_i);

  assert_invert_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (toggle_en && terminal && !load_i) |=> level_o != $past(level_o));

  assert_steady_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (toggle_en && !terminal && !load_i) |=> $stable(level_o));
endmodule

// File: rtl/sqw_pin.sv
module sqw_pin
  import sqw_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       level_i,
  input  logic       oe_i,
  input  logic [1:0] dir_i,
  output logic       pin_o,
  output logic       pin_oe_o
);
  assign pin_oe_o = oe_i && (dir_i == DIR_OUT);
  assign pin_o    = pin_oe_o && level_i;

  assert_pin_gate_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pin_oe_o |-> !pin_o);

  assert_pin_follow_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pin_oe_o |-> pin_o == level_i);
endmodule

// File: rtl/sqwave_gen.sv
module sqwave_gen
  import sqw_pkg::*;
#(
  parameter int unsigned CNT_W  = 16,
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic              wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              rd_addr_i,
  output logic [DATA_W-1:0] rd_data_o,
  output logic              pin_o,
  output logic              pin_oe_o
);
  logic [CNT_W-1:0]  count;
  logic [MODE_W-1:0] mode;
  logic              diag;
  logic              oe;
  logic [1:0]        dir;
  logic              ctrl_load;
  logic              level;

  initial begin
    assert (CNT_W + MODE_W + 2 <= DATA_W)
      else $error("control word does not fit the data width");
  end

  sqw_regs #(.CNT_W(CNT_W), .DATA_W(DATA_W)) u_regs (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .wr_en_i     (wr_en_i),
    .wr_addr_i   (wr_addr_i),
    .wr_data_i   (wr_data_i),
    .rd_addr_i   (rd_addr_i),
    .level_i     (level),
    .count_o     (count),
    .mode_o      (mode),
    .diag_o      (diag),
    .oe_o        (oe),
    .dir_o       (dir),
    .ctrl_load_o (ctrl_load),
    .rd_data_o   (rd_data_o)
  );

  sqw_tick #(.CNT_W(CNT_W)) u_tick (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .load_i  (ctrl_load),
    .count_i (count),
    .mode_i  (mode),
    .level_o (level)
  );

  sqw_pin u_pin (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .level_i  (level),
    .oe_i     (oe),
    .dir_i    (dir),
    .pin_o    (pin_o),
    .pin_oe_o (pin_oe_o)
  );

  // R7: an all-zero control word brings the output to rest
  assert_zero_rest_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl_load && wr_data_i == '0) |=> !level && mode == '0 && count == '0);

  logic unused_diag;
  assign unused_diag = diag;
endmodule

// File: tb/sqwave_gen_tb.sv
module sqwave_gen_tb;
  localparam int CLK_PERIOD = 10;
  localparam int LVL_BIT = 20;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic        wr_addr = 1'b0;
  logic [31:0] wr_data = '0;
  logic        rd_addr = 1'b0;
  logic [31:0] rd_data;
  logic        pin, pin_oe;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sqwave_gen u_dut (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_addr_i(wr_addr),
    .wr_data_i(wr_data), .rd_addr_i(rd_addr), .rd_data_o(rd_data),
    .pin_o(pin), .pin_oe_o(pin_oe)
  );

  function automatic logic [31:0] ctrl_word(input logic [15:0] c, input logic [2:0] m,
                                            input logic d);
    return {12'b0, d, m, c};
  endfunction

  // level after the k-th edge following the write edge
  function automatic logic exp_level(input int k, input int c, input logic [2:0] m);
    if (m != 3'b111) return 1'b0;
    return 1'((k / (c + 1)) % 2);
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // called aligned to a falling edge; returns on the next falling edge
  task automatic wr(input logic a, input logic [31:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  function automatic logic cur_level();
    return rd_data[LVL_BIT];
  endfunction

  // follow the phase from just after a write edge for n edges
  task automatic follow(input string req, input int c, input logic [2:0] m, input int n,
                        input bit gate_on);
    int bad = 0;
    rd_addr = 1'b0;
    for (int k = 0; k <= n; k++) begin
      #1;
      if (cur_level() !== exp_level(k, c, m) ||
          (gate_on && pin !== exp_level(k, c, m))) begin
        if (bad == 0)
          $display("FAIL %s edge=%0d actual=%0b expected=%0b", req, k, cur_level(),
                   exp_level(k, c, m));
        bad++;
      end
      @(negedge clk);
    end
    checks++;
    if (bad != 0) errors++;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    // R1: reset state
    rd_addr = 1'b0; #1; check("R1 ctrl", rd_data, 32'h0);
    rd_addr = 1'b1; #1; check("R1 gpc", rd_data, 32'h0);
    check("R1 pin", {30'b0, pin_oe, pin}, 32'h0);
    rst_n = 1'b1;
    @(negedge clk);

    // R2: field placement
    wr(1'b0, ctrl_word(16'hA5C3, 3'b010, 1'b1));
    rd_addr = 1'b0; #1; check("R2 readback", rd_data, 32'h000A_A5C3);
    @(negedge clk);
    // R6: non-toggle mode stays low
    follow("R6 mode2", 3, 3'b010, 20, 1'b0);

    // R8: enable the pin (oe=1 dir=00)
    wr(1'b1, 32'h1);
    rd_addr = 1'b1; #1; check("R8 gpc readback", rd_data, 32'h1);
    check("R8 oe on", {31'b0, pin_oe}, 32'h1);
    @(negedge clk);

    // R3/R9: directed toggle, pin follows
    wr(1'b0, ctrl_word(16'd4, 3'b111, 1'b0));
    follow("R3 R9 count4", 4, 3'b111, 40, 1'b1);

    // R10: count zero
    wr(1'b0, ctrl_word(16'd0, 3'b111, 1'b0));
    follow("R10 count0", 0, 3'b111, 9, 1'b1);

    // R4: count 63 -> period 128, measured between rising edges
    begin
      int rise1 = -1, rise2 = -1;
      logic prev = 1'b0;
      wr(1'b0, ctrl_word(16'd63, 3'b111, 1'b0));
      rd_addr = 1'b0;
      for (int k = 0; k < 300 && rise2 < 0; k++) begin
        #1;
        if (!prev && cur_level()) begin
          if (rise1 < 0) rise1 = k; else rise2 = k;
        end
        prev = cur_level();
        @(negedge clk);
      end
      check("R4 first rise", rise1, 64);
      check("R4 period", rise2 - rise1, 128);
    end

    // R5: write on the very edge of a scheduled inversion
    wr(1'b0, ctrl_word(16'd5, 3'b111, 1'b0));
    repeat (5) @(negedge clk);
    rd_addr = 1'b0; #1; check("R5 before", {31'b0, cur_level()}, 32'h0);
    @(negedge clk);
    // now just after edge 6? no: realign - issue write that lands on edge 6
    // (the previous negedge wait consumed edge 6, so restart the scheme)
    wr(1'b0, ctrl_word(16'd5, 3'b111, 1'b0));
    repeat (5) @(negedge clk);
    wr(1'b0, ctrl_word(16'd3, 3'b111, 1'b0));
    rd_addr = 1'b0; #1; check("R5 collide low", {31'b0, cur_level()}, 32'h0);
    follow("R5 new phase", 3, 3'b111, 20, 1'b1);

    // R8: direction field blocks the pin while level is high
    wr(1'b0, ctrl_word(16'd7, 3'b111, 1'b0));
    repeat (8) @(negedge clk);
    #1; check("R8 level high", {31'b0, cur_level()}, 32'h1);
    check("R8 pin high", {31'b0, pin}, 32'h1);
    wr(1'b1, 32'h3);
    #1; check("R8 dir blocks", {30'b0, pin_oe, pin}, 32'h0);
    wr(1'b1, 32'h0);
    #1; check("R8 oe off", {30'b0, pin_oe, pin}, 32'h0);
    wr(1'b1, 32'h1);

    // R7: zero write restores power-on state, general-purpose word kept
    wr(1'b0, 32'h0);
    rd_addr = 1'b0; #1; check("R7 ctrl zero", rd_data, 32'h0);
    rd_addr = 1'b1; #1; check("R7 gpc kept", rd_data, 32'h1);
    @(negedge clk);
    follow("R7 rest", 2, 3'b000, 15, 1'b1);

    // random mix
    for (int i = 0; i < 40; i++) begin
      int c = int'($urandom_range(0, 40));
      logic [2:0] m = ($urandom_range(0, 2) != 0) ? 3'b111 : 3'($urandom_range(0, 6));
      logic d = 1'($urandom_range(0, 1));
      wr(1'b0, ctrl_word(16'(c), m, d));
      rd_addr = 1'b0; #1;
      check("R2 random readback", rd_data & 32'h000F_FFFF, ctrl_word(16'(c), m, d));
      follow(m == 3'b111 ? "R3 random" : "R6 random", c, m, 3 * (c + 1) + 2, 1'b1);
    end

    done = 1'b1;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule